// File: doc/BRIEF.md
# Banked Internal Data Memory

This block is the 256-byte internal data RAM of an 8-bit microcontroller core, with its access front end. The core presents one request per cycle. Each request carries an addressing mode, an 8-bit address, a byte/bit flag, a read/write flag and write data. The front end resolves the request to one of five targets:

- the lower RAM;
- the upper RAM;
- a working-register slot in one of four banks;
- a single bit in the bit-addressable bytes;
- a forward to an external special-function-register (SFR) port.

The block also keeps a full-ascending stack pointer. Push and pop strobes use it.

Two select bits choose which of the four eight-register banks is active. In register mode the request names a register by number. In register-indirect mode the request takes a byte pointer from register 0 or register 1 of the active bank. A high address in direct mode reaches the SFR port, and the same address in indirect mode reaches RAM. Reads, including pops, return one cycle later with a valid strobe. A stack operation that collides with a port access is refused, and a busy flag reports the refusal.

Top module: `idm_core`

## Requirements
- R1: In direct mode (req_mode=0, req_bit=0), an address below 0x80 reads or writes that RAM byte. An address of 0x80 or above raises sfr_valid in the same cycle with sfr_addr=req_addr, sfr_bit=0 and sfr_wdata=req_wdata. A direct read of such an address returns sfr_rdata, as sampled in the request cycle.
- R2: In indirect mode (req_mode=1, req_bit=0), every address 0x00 to 0xFF reaches RAM, and sfr_valid stays low.
- R3: In register mode (req_mode=2, req_bit=0), req_addr[2:0]=n selects the byte at bank_sel*8+n, where bank_sel is the 2-bit bank number.
- R4: In register-indirect mode (req_mode=3, req_bit=0), req_addr[0] picks register 0 or register 1 of the active bank. The content of that register is used as the full 8-bit RAM address of the access.
- R5: With req_bit=1 and req_addr below 0x80, the target is bit req_addr[2:0] of byte 0x20+req_addr[6:3], and req_mode is ignored. A read returns that bit in rd_data[0] with rd_data[7:1]=0. A write stores req_wdata[0].
- R6: A bit write changes only the selected bit of its byte. The other seven bits keep their values.
- R7: With req_bit=1 and req_addr of 0x80 or above, the access goes to the SFR port with sfr_bit=1, sfr_addr=req_addr and sfr_wdata={7'b0, req_wdata[0]}. A read returns {7'b0, sfr_rdata[0]}.
- R8: After reset sp_value is 0x07. An accepted push first increments sp_value and then writes push_data at the new value, so the first push after reset lands at 0x08.
- R9: An accepted pop returns the byte at sp_value and then decrements sp_value. The stack pointer wraps: 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R10: Each read request and each accepted pop raises rd_valid with rd_data on the next cycle only. A write request produces no rd_valid, and rd_valid is 0 after reset.
- R11: busy is high in the same cycle when push or pop coincides with req_valid, or when push and pop are both high. Such a stack operation is dropped: sp_value is unchanged, RAM is not written and no pop response appears. A coinciding port request still executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Port request present this cycle |
| req_mode | input | 2 | Addressing mode: 0 direct, 1 indirect, 2 register, 3 register-indirect |
| req_addr | input | 8 | Byte address, bit address or register number |
| req_bit | input | 1 | 1 selects a single-bit access |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 8 | Write data (bit value in bit 0 for bit writes) |
| bank_sel | input | 2 | Active register bank |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| push_data | input | 8 | Byte to push |
| busy | output | 1 | Stack operation refused this cycle |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response data |
| sp_value | output | 8 | Current stack pointer |
| sfr_valid | output | 1 | SFR port access this cycle |
| sfr_write | output | 1 | SFR access is a write |
| sfr_bit | output | 1 | SFR access is a bit access |
| sfr_addr | output | 8 | SFR byte or bit address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, same cycle |

## Verification
The SFR forward and busy outputs are combinational, so the bench checks them one time step after it drives a request, within the request's own cycle. Read data, pop data and rd_valid come from a register and are due one clock edge later. The bench samples them at the next falling edge, together with sp_value, which also moves on that edge. Each ignored or refused operation is made visible at the ports: a later read of the byte it could have written, the stack pointer, and the absence of rd_valid.

// File: rtl/idm_pkg.sv
// Package idm_pkg
// Shared types for the banked internal data memory. Assumes an 8-bit
// data path; the bit-position width is derived from it.
package idm_pkg;
    localparam int IDM_DW   = 8;
    localparam int IDM_BITW = $clog2(IDM_DW);

    typedef enum logic [1:0] {
        AM_DIRECT   = 2'd0,
        AM_INDIRECT = 2'd1,
        AM_REG      = 2'd2,
        AM_REGIND   = 2'd3
    } addr_mode_e;

    typedef struct packed {
        logic                to_sfr;
        logic                is_bit;
        logic [7:0]          ram_addr;
        logic [IDM_BITW-1:0] bit_pos;
    } route_t;
endpackage

// File: rtl/idm_decode.sv
// Module idm_decode
// Resolves one request (mode, address, bit flag, bank) to a target:
// a RAM byte, a bit of a RAM byte, or the SFR port. It also forms the
// address of the pointer register used by register-indirect mode and
// takes that register's current content back as ptr_q.
// Assumes AW = 8 (the route struct carries an 8-bit RAM address).
// Purely combinational.
module idm_decode
    import idm_pkg::*;
#(
    parameter int          AW       = 8,
    parameter int          REG_BITS = 3,
    parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] addr,
    input  logic          is_bit,
    input  logic [1:0]    bank,
    input  logic [AW-1:0] ptr_q,
    output logic [AW-1:0] ptr_addr,
    output route_t        route
);
    localparam int BSH = IDM_BITW;

    logic high_half;
    logic [AW-1:0] bank_base;

    assign high_half = addr[AW-1];
    assign bank_base = AW'(bank) << REG_BITS;

    // Pointer register: R0 or R1 of the active bank
    assign ptr_addr = bank_base | AW'(addr[0]);

    // Route selection by bit flag first, then addressing mode
    always_comb begin
        route = '0;
        if (is_bit) begin
            route.is_bit  = 1'b1;
            route.bit_pos = addr[BSH-1:0];
            if (high_half) begin
                route.to_sfr   = 1'b1;
                route.ram_addr = addr;
            end else begin
                route.ram_addr = BIT_BASE + AW'(addr[AW-2:BSH]);
            end
        end else begin
            unique case (addr_mode_e'(mode))
                AM_DIRECT: begin
                    route.to_sfr   = high_half;
                    route.ram_addr = addr;
                end
                AM_INDIRECT: route.ram_addr = addr;
                AM_REG:      route.ram_addr = bank_base | AW'(addr[REG_BITS-1:0]);
                AM_REGIND:   route.ram_addr = ptr_q;
                default:     route.ram_addr = addr;
            endcase
        end
    end
endmodule

// File: rtl/idm_ram.sv
// Module idm_ram
// Flop-array data RAM of 2**AW words with one masked write port and two
// asynchronous read ports. Port A serves the pointer fetch; port B
// serves data reads and the read half of a bit read-modify-write.
// Contents are not reset; software must write before it reads.
module idm_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wmask,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Masked write: bits outside wmask keep their stored value
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/idm_stack.sv
// Module idm_stack
// Full-ascending stack pointer. sp_q names the last used location and
// sp_inc the slot that a push writes. Accepted push and pop are
// exclusive (the caller guarantees this). Wraps modulo 2**AW.
module idm_stack #(
    parameter int            AW       = 8,
    parameter logic [AW-1:0] SP_RESET = 8'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_go,
    input  logic          pop_go,
    output logic [AW-1:0] sp_q,
    output logic [AW-1:0] sp_inc
);
    assign sp_inc = sp_q + 1'b1;

    // Pointer update: increment on push, decrement on pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_RESET;
        end else if (push_go) begin
            sp_q <= sp_inc;
        end else if (pop_go) begin
            sp_q <= sp_q - 1'b1;
        end
    end
endmodule

// File: rtl/idm_core.sv
// Module idm_core
// Top of the banked internal data memory. It decodes port requests,
// forwards SFR-space accesses to the side port in the same cycle,
// performs byte, bit (read-modify-write), push and pop accesses on the
// RAM, and returns reads one cycle later. Assumptions: at most one port
// request per cycle; the SFR responder answers combinationally; a stack
// operation colliding with a request, or push with pop, is refused.
module idm_core
    import idm_pkg::*;
#(
    parameter int            AW       = 8,
    parameter logic [AW-1:0] SP_RESET = 8'h07,
    parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_mode,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_bit,
    input  logic             req_write,
    input  logic [IDM_DW-1:0] req_wdata,
    input  logic [1:0]       bank_sel,
    input  logic             push,
    input  logic             pop,
    input  logic [IDM_DW-1:0] push_data,
    output logic             busy,
    output logic             rd_valid,
    output logic [IDM_DW-1:0] rd_data,
    output logic [AW-1:0]    sp_value,
    output logic             sfr_valid,
    output logic             sfr_write,
    output logic             sfr_bit,
    output logic [AW-1:0]    sfr_addr,
    output logic [IDM_DW-1:0] sfr_wdata,
    input  logic [IDM_DW-1:0] sfr_rdata
);
    localparam int DW = IDM_DW;

    route_t        route;
    logic [AW-1:0] ptr_addr, ptr_q;
    logic [AW-1:0] sp_inc;
    logic          push_go, pop_go;
    logic          ram_we;
    logic [AW-1:0] ram_waddr, ram_raddr;
    logic [DW-1:0] ram_wmask, ram_wdata, ram_rdata;
    logic [DW-1:0] bit_mask, bit_rd, sfr_rd;
    logic [DW-1:0] rd_next;
    logic          rd_fire;

    // Stack arbitration: port request or push+pop together refuse it
    assign busy    = (push || pop) && (req_valid || (push && pop));
    assign push_go = push && !busy;
    assign pop_go  = pop && !busy;

    idm_decode #(
        .AW       (AW),
        .REG_BITS (3),
        .BIT_BASE (BIT_BASE)
    ) u_decode (
        .mode     (req_mode),
        .addr     (req_addr),
        .is_bit   (req_bit),
        .bank     (bank_sel),
        .ptr_q    (ptr_q),
        .ptr_addr (ptr_addr),
        .route    (route)
    );

    idm_stack #(
        .AW       (AW),
        .SP_RESET (SP_RESET)
    ) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_go (push_go),
        .pop_go  (pop_go),
        .sp_q    (sp_value),
        .sp_inc  (sp_inc)
    );

    // Single-bit mask for bit writes
    assign bit_mask = DW'(1) << route.bit_pos;

    // RAM write port: push or a non-SFR port write (never both)
    always_comb begin
        ram_we    = push_go || (req_valid && req_write && !route.to_sfr);
        ram_waddr = route.ram_addr;
        ram_wmask = route.is_bit ? bit_mask : {DW{1'b1}};
        ram_wdata = route.is_bit ? {DW{req_wdata[0]}} : req_wdata;
        if (push_go) begin
            ram_waddr = sp_inc;
            ram_wmask = {DW{1'b1}};
            ram_wdata = push_data;
        end
    end

    // Data read address: pop reads top of stack, else the decoded byte
    assign ram_raddr = pop_go ? sp_value : route.ram_addr;

    idm_ram #(
        .AW (AW),
        .DW (DW)
    ) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wmask   (ram_wmask),
        .wdata   (ram_wdata),
        .raddr_a (ptr_addr),
        .rdata_a (ptr_q),
        .raddr_b (ram_raddr),
        .rdata_b (ram_rdata)
    );

    // SFR side port driven straight from the request
    assign sfr_valid = req_valid && route.to_sfr;
    assign sfr_write = req_write;
    assign sfr_bit   = route.is_bit;
    assign sfr_addr  = req_addr;
    assign sfr_wdata = route.is_bit ? {{(DW-1){1'b0}}, req_wdata[0]} : req_wdata;

    // Response data selection by source
    assign bit_rd  = {{(DW-1){1'b0}}, ram_rdata[route.bit_pos]};
    assign sfr_rd  = route.is_bit ? {{(DW-1){1'b0}}, sfr_rdata[0]} : sfr_rdata;
    assign rd_fire = (req_valid && !req_write) || pop_go;

    always_comb begin
        if (pop_go) begin
            rd_next = ram_rdata;
        end else if (route.to_sfr) begin
            rd_next = sfr_rd;
        end else if (route.is_bit) begin
            rd_next = bit_rd;
        end else begin
            rd_next = ram_rdata;
        end
    end

    // Registered read response, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) begin
                rd_data <= rd_next;
            end
        end
    end
endmodule

// File: rtl/idm_core_sva.sv
// Module idm_core_sva
// Port-level properties of idm_core: SFR routing by mode, stack pointer
// movement, busy refusal and read-response timing. Bound to every
// idm_core instance by the bind statement at the end of this file.
module idm_core_sva
    import idm_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_mode,
    input logic [AW-1:0] req_addr,
    input logic          req_bit,
    input logic          req_write,
    input logic          push,
    input logic          pop,
    input logic          busy,
    input logic          sfr_valid,
    input logic          rd_valid,
    input logic [AW-1:0] sp_value
);
    // R1: SFR port only for direct or bit accesses to the high half
    assert_sfr_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_valid |-> (req_valid && req_addr[AW-1] &&
                       (req_bit || req_mode == AM_DIRECT)));

    // R2: non-direct byte modes never reach the SFR port
    assert_indirect_ram_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_bit && req_mode != AM_DIRECT) |-> !sfr_valid);

    // R8: accepted push increments the stack pointer
    assert_push_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !busy) |=> (sp_value == $past(sp_value) + 1'b1));

    // R9: accepted pop decrements the stack pointer
    assert_pop_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !busy) |=> (sp_value == $past(sp_value) - 1'b1));

    // R11: collision raises busy
    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (push || pop)) |-> busy);

    // R11: refused stack operation leaves the pointer alone
    assert_sp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sp_value));

    // R10: a read request is answered on the next cycle
    assert_rd_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R10: a write request produces no response
    assert_wr_no_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rd_valid);
endmodule

bind idm_core idm_core_sva #(.AW(AW)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_addr  (req_addr),
    .req_bit   (req_bit),
    .req_write (req_write),
    .push      (push),
    .pop       (pop),
    .busy      (busy),
    .sfr_valid (sfr_valid),
    .rd_valid  (rd_valid),
    .sp_value  (sp_value)
);

// File: tb/idm_core_tb.sv
// Bench for idm_core: a vector table walked by one loop, then directed
// tests for reset, the SFR side port, stack wrap and busy refusal.
module idm_core_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid, req_bit, req_write, push, pop;
    logic [1:0] req_mode, bank_sel;
    logic [7:0] req_addr, req_wdata, push_data;
    logic       busy, rd_valid, sfr_valid, sfr_write, sfr_bit;
    logic [7:0] rd_data, sp_value, sfr_addr, sfr_wdata, sfr_rdata;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    // SFR responder model: data is a fixed function of the address
    assign sfr_rdata = sfr_addr ^ 8'h5A;

    idm_core u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_mode (req_mode), .req_addr (req_addr),
        .req_bit (req_bit), .req_write (req_write), .req_wdata (req_wdata),
        .bank_sel (bank_sel), .push (push), .pop (pop), .push_data (push_data),
        .busy (busy), .rd_valid (rd_valid), .rd_data (rd_data),
        .sp_value (sp_value), .sfr_valid (sfr_valid), .sfr_write (sfr_write),
        .sfr_bit (sfr_bit), .sfr_addr (sfr_addr), .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata)
    );

    // {tag, mode, addr, bit, write, wdata, bank, expect_valid, expect_data}
    localparam int NV = 21;
    localparam logic [34:0] VECS [NV] = '{
        {4'd1, 2'd0, 8'h30, 1'b0, 1'b1, 8'hA5, 2'd0, 1'b0, 8'h00}, // R1 write low
        {4'd1, 2'd0, 8'h30, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'hA5}, // R1 read low
        {4'd2, 2'd1, 8'h90, 1'b0, 1'b1, 8'h3C, 2'd0, 1'b0, 8'h00}, // R2 upper write
        {4'd2, 2'd1, 8'h90, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h3C}, // R2 upper read
        {4'd1, 2'd0, 8'h90, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'hCA}, // R1 SFR read
        {4'd3, 2'd2, 8'h05, 1'b0, 1'b1, 8'h77, 2'd2, 1'b0, 8'h00}, // R3 bank2 r5
        {4'd3, 2'd0, 8'h15, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h77}, // R3 at 0x15
        {4'd3, 2'd2, 8'h00, 1'b0, 1'b1, 8'h90, 2'd1, 1'b0, 8'h00}, // R3 bank1 r0
        {4'd4, 2'd3, 8'h00, 1'b0, 1'b0, 8'h00, 2'd1, 1'b1, 8'h3C}, // R4 read @r0
        {4'd4, 2'd3, 8'h00, 1'b0, 1'b1, 8'h41, 2'd1, 1'b0, 8'h00}, // R4 write @r0
        {4'd4, 2'd1, 8'h90, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h41}, // R4 result
        {4'd5, 2'd0, 8'h22, 1'b0, 1'b1, 8'h00, 2'd0, 1'b0, 8'h00}, // R5 clear 0x22
        {4'd5, 2'd0, 8'h13, 1'b1, 1'b1, 8'h01, 2'd0, 1'b0, 8'h00}, // R5 set bit 0x13
        {4'd5, 2'd0, 8'h22, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'h08}, // R5 byte 0x22
        {4'd6, 2'd0, 8'h2F, 1'b0, 1'b1, 8'h7F, 2'd0, 1'b0, 8'h00}, // R6 seed 0x2F
        {4'd6, 2'd2, 8'h7F, 1'b1, 1'b1, 8'h01, 2'd0, 1'b0, 8'h00}, // R6 set bit7
        {4'd6, 2'd0, 8'h78, 1'b1, 1'b1, 8'h00, 2'd0, 1'b0, 8'h00}, // R6 clear bit0
        {4'd6, 2'd0, 8'h2F, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1, 8'hFE}, // R6 result
        {4'd5, 2'd0, 8'h13, 1'b1, 1'b0, 8'h00, 2'd0, 1'b1, 8'h01}, // R5 bit read 1
        {4'd5, 2'd0, 8'h12, 1'b1, 1'b0, 8'h00, 2'd0, 1'b1, 8'h00}, // R5 bit read 0
        {4'd7, 2'd0, 8'h81, 1'b1, 1'b0, 8'h00, 2'd0, 1'b1, 8'h01}  // R7 SFR bit read
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 1'b0; req_bit = 1'b0; req_write = 1'b0;
        push = 1'b0; pop = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] m, input logic [7:0] a, input logic b,
                         input logic w, input logic [7:0] d, input logic [1:0] bk);
        req_valid = 1'b1; req_mode = m; req_addr = a; req_bit = b;
        req_write = w; req_wdata = d; bank_sel = bk;
    endtask

    initial begin
        rst_n = 1'b0; req_mode = 2'd0; req_addr = 8'h00; req_wdata = 8'h00;
        bank_sel = 2'd0; push_data = 8'h00;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 / R10: reset state
        chk("R8 reset sp", sp_value, 8'h07);
        chk("R10 reset rd_valid", {7'b0, rd_valid}, 8'h00);
        chk("R11 reset busy", {7'b0, busy}, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [34:0] v;
            string tg;
            v = VECS[i];
            tg = $sformatf("R%0d vec%0d", v[34:31], i);
            drive(v[30:29], v[28:21], v[20], v[19], v[18:11], v[10:9]);
            tick();
            idle();
            chk({tg, " rd_valid"}, {7'b0, rd_valid}, {7'b0, v[8]});
            if (v[8]) chk({tg, " rd_data"}, rd_data, v[7:0]);
        end

        // R10: response lasts a single cycle
        tick();
        chk("R10 rd_valid drops", {7'b0, rd_valid}, 8'h00);

        // R1: direct write above 0x7F forwarded to the SFR port
        drive(2'd0, 8'hA0, 1'b0, 1'b1, 8'h12, 2'd0);
        #1;
        chk("R1 sfr_valid", {7'b0, sfr_valid}, 8'h01);
        chk("R1 sfr_addr", sfr_addr, 8'hA0);
        chk("R1 sfr_wdata", sfr_wdata, 8'h12);
        chk("R1 sfr flags", {6'b0, sfr_write, sfr_bit}, 8'h02);
        @(negedge clk);
        // R2: indirect write to the same address stays in RAM
        drive(2'd1, 8'hA0, 1'b0, 1'b1, 8'h12, 2'd0);
        #1;
        chk("R2 no sfr_valid", {7'b0, sfr_valid}, 8'h00);
        @(negedge clk);
        // R7: bit write above 0x7F
        drive(2'd1, 8'h85, 1'b1, 1'b1, 8'hFF, 2'd0);
        #1;
        chk("R7 sfr_valid", {7'b0, sfr_valid}, 8'h01);
        chk("R7 sfr_bit", {7'b0, sfr_bit}, 8'h01);
        chk("R7 sfr_wdata", sfr_wdata, 8'h01);
        chk("R7 sfr_addr", sfr_addr, 8'h85);
        @(negedge clk);
        // Seed byte 0x01 for the R11 write check
        drive(2'd0, 8'h01, 1'b0, 1'b1, 8'hC3, 2'd0);
        tick();
        idle();

        // R8: first push lands at 0x08
        push = 1'b1; push_data = 8'h11;
        tick();
        idle();
        chk("R8 sp after push", sp_value, 8'h08);
        chk("R8 no response", {7'b0, rd_valid}, 8'h00);
        drive(2'd0, 8'h08, 1'b0, 1'b0, 8'h00, 2'd0);
        tick();
        idle();
        chk("R8 pushed byte", rd_data, 8'h11);

        // R9: pop returns top then decrements
        pop = 1'b1;
        tick();
        idle();
        chk("R9 pop valid", {7'b0, rd_valid}, 8'h01);
        chk("R9 pop data", rd_data, 8'h11);
        chk("R9 sp after pop", sp_value, 8'h07);
        for (int k = 0; k < 7; k++) begin
            pop = 1'b1;
            tick();
        end
        idle();
        chk("R9 sp at zero", sp_value, 8'h00);
        pop = 1'b1;
        tick();
        idle();
        chk("R9 wrap down", sp_value, 8'hFF);
        push = 1'b1; push_data = 8'h5E;
        tick();
        idle();
        chk("R9 wrap up", sp_value, 8'h00);
        drive(2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 2'd0);
        tick();
        idle();
        chk("R9 wrapped push byte", rd_data, 8'h5E);

        // R11: push colliding with a read request
        drive(2'd0, 8'h30, 1'b0, 1'b0, 8'h00, 2'd0);
        push = 1'b1; push_data = 8'h99;
        #1;
        chk("R11 busy on collision", {7'b0, busy}, 8'h01);
        @(negedge clk);
        idle();
        chk("R11 port read done", rd_data, 8'hA5);
        chk("R11 sp held", sp_value, 8'h00);
        // R11: push and pop together
        push = 1'b1; pop = 1'b1; push_data = 8'h99;
        #1;
        chk("R11 busy push+pop", {7'b0, busy}, 8'h01);
        @(negedge clk);
        idle();
        chk("R11 no pop response", {7'b0, rd_valid}, 8'h00);
        chk("R11 sp held again", sp_value, 8'h00);
        drive(2'd0, 8'h01, 1'b0, 1'b0, 8'h00, 2'd0);
        tick();
        idle();
        chk("R11 no push write", rd_data, 8'hC3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: ends a hung run as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R10 actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule